// File: doc/BRIEF.md
# DMA Cache-Line Segmenting Sequencer

This block takes one DMA request at a time and turns it into a chain of memory transactions. A request gives a start byte address, a byte length, a load or store type, a flag saying whether a data buffer comes with it and, for stores, the bytes to write. The block cuts the request at cache-line boundaries. It issues one segment at a time on a valid/ready interface and waits for that segment's response before it issues the next.

The first segment keeps the start address's offset within its line. Every later segment starts on a line boundary. For loads, the bytes from each returned line are packed into an internal request buffer at the running completed position, and the buffer is visible on `rd_data`. For stores, each segment carries the right slice of the write bytes, placed at the right lanes of the line and marked by byte enables. When the last segment's response arrives, the block pulses `done` and is free for a new request. A request made while the block is busy is refused at once and is not queued. A malformed request is rejected without starting. A response that does not fit the current state is flagged and otherwise ignored.

Top module: `dma_seg_sequencer`

## Requirements
- R1: While busy, any `req_valid` is answered in the same cycle with `req_status` = 2'b10 (full). It is not stored, and no segment beyond those of the active request is ever issued.
- R2: In the idle state, a request with `req_type` other than 2'b00 (load) or 2'b01 (store), or with `req_len` of 0, or with `req_len` greater than BUF_BYTES, gets `req_status` = 2'b11 (error) and does not make the block busy.
- R3: The first segment has `seg_addr` equal to the start address. Its `seg_len` is the smaller of `req_len` and LINE_BYTES minus the start offset, where the start offset is the start address modulo LINE_BYTES.
- R4: Each later segment has `seg_addr` equal to the start address plus the bytes already completed, and this address is line-aligned. Its `seg_len` is the smaller of the remaining bytes and LINE_BYTES.
- R5: At most one segment is outstanding. `seg_valid` stays low from the accepted handshake until that segment's response, and `seg_addr`/`seg_len` stay stable while `seg_valid` is high and `seg_ready` is low.
- R6: A legal request in the idle state gets `req_status` = 2'b01 (issued), and `busy` is high from the next cycle. `done` pulses for one cycle in the cycle after the final response is taken, and `busy` is low in that same cycle.
- R7: For a load with a buffer, each read response (`rsp_is_ack` = 0) supplies bytes from line lane (start offset for the first segment, 0 after that) onward. These are written to `rd_data` byte positions starting at the completed count. After `done`, `rd_data` bytes 0..len-1 hold memory bytes start..start+len-1, and all higher bytes are zero.
- R8: For a store with a buffer, `seg_be` bit i is set exactly for lanes offset..offset+seg_len-1. `seg_data` byte lane offset+k carries write byte (completed+k), and lanes that are not enabled carry zero.
- R9: A request without a buffer still runs every segment and completes. Store segments carry all-zero `seg_data`, and a load leaves `rd_data` all zero.
- R10: A response (`rsp_valid`) taken while no segment is awaiting one, or whose kind does not match the request (ack for a load, read data for a store), raises `proto_err` for one cycle in the following cycle and changes no transfer state.
- R11: `seg_line_addr` equals `seg_addr` with its low log2(LINE_BYTES) bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, answered in the same cycle |
| req_type | input | 2 | 00 load, 01 store, others illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count, 1..BUF_BYTES |
| req_has_buf | input | 1 | Request carries a data buffer |
| req_wdata | input | BUF_BYTES*8 | Store bytes, byte k at bits 8k+7:8k |
| req_status | output | 2 | 00 none, 01 issued, 10 full, 11 error |
| busy | output | 1 | A request is active |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment taken by memory side |
| seg_addr | output | ADDR_W | Segment byte address |
| seg_line_addr | output | ADDR_W | Line-aligned address of the segment |
| seg_len | output | LEN_W | Segment byte count |
| seg_write | output | 1 | Segment is a store |
| seg_be | output | LINE_BYTES | Byte lanes covered by the segment |
| seg_data | output | LINE_BYTES*8 | Store data placed in line lanes |
| rsp_valid | input | 1 | One-cycle response pulse |
| rsp_is_ack | input | 1 | 1 store acknowledge, 0 read data |
| rsp_data | input | LINE_BYTES*8 | Returned line for reads |
| done | output | 1 | One-cycle completion pulse |
| proto_err | output | 1 | One-cycle protocol error pulse |
| rd_data | output | BUF_BYTES*8 | Request buffer contents |

## Verification
The bench aims at unaligned starts that fit within one line, starts that cross two or more line boundaries, aligned multi-line stores, and a maximum-length load spread over five lines. If the first-segment offset were applied to later segments, or later segments were not aligned, the scoreboard would see a wrong address, length or byte enable. If read bytes were taken from the wrong lane, the packed buffer after completion would hold shifted data. Stalls on `seg_ready`, a request made while busy, illegal types and lengths, responses while idle and responses of the wrong kind are all injected. A design that queued or accepted such a request would issue an unexpected segment. A design that acted on a stray response would finish early or corrupt the buffer.

// File: rtl/dma_seg_pkg.sv
`timescale 1ns/1ps
package dma_seg_pkg;

    localparam logic [1:0] TYPE_LOAD  = 2'b00;
    localparam logic [1:0] TYPE_STORE = 2'b01;

    typedef enum logic [1:0] {
        ST_NONE   = 2'b00,
        ST_ISSUED = 2'b01,
        ST_FULL   = 2'b10,
        ST_ERROR  = 2'b11
    } req_status_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_ISSUE = 2'b01,
        PH_WAIT  = 2'b10
    } phase_e;

endpackage

// File: rtl/dma_seg_plan.sv
`timescale 1ns/1ps
// Computes the current segment from the start address and the completed count.
module dma_seg_plan #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LEN_W      = 7,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [LEN_W-1:0]      total_len,
    input  logic [LEN_W-1:0]      done_bytes,
    output logic [ADDR_W-1:0]     seg_addr,
    output logic [OFF_W-1:0]      seg_off,
    output logic [LEN_W-1:0]      seg_len,
    output logic [LINE_BYTES-1:0] seg_be
);
    localparam logic [LEN_W:0] LINE_X = (LEN_W+1)'(LINE_BYTES);

    logic [LEN_W:0] off_x, room_x, remain_x, len_x, end_x;

    always_comb begin
        seg_off  = (done_bytes == '0) ? start_addr[OFF_W-1:0] : '0;
        off_x    = (LEN_W+1)'(seg_off);
        room_x   = LINE_X - off_x;
        remain_x = {1'b0, total_len - done_bytes};
        len_x    = (remain_x < room_x) ? remain_x : room_x;
        end_x    = off_x + len_x;
        seg_len  = len_x[LEN_W-1:0];
        seg_addr = start_addr + ADDR_W'(done_bytes);
    end

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
        assign seg_be[i] = ((LEN_W+1)'(i) >= off_x) && ((LEN_W+1)'(i) < end_x);
    end

endmodule

// File: rtl/dma_seg_wslice.sv
`timescale 1ns/1ps
// Places the store bytes for the current segment into their line lanes.
module dma_seg_wslice #(
    parameter int LINE_BYTES = 16,
    parameter int BUF_BYTES  = 64,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int BIDX_W    = $clog2(BUF_BYTES)
) (
    input  logic [BUF_BYTES*8-1:0]  buf_data,
    input  logic [BIDX_W-1:0]       done_lo,
    input  logic [OFF_W-1:0]        seg_off,
    input  logic [LINE_BYTES-1:0]   seg_be,
    input  logic                    enable,
    output logic [LINE_BYTES*8-1:0] line_data
);
    logic [7:0] buf_b [BUF_BYTES];

    for (genvar j = 0; j < BUF_BYTES; j++) begin : g_unpack
        assign buf_b[j] = buf_data[j*8 +: 8];
    end

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_lane
        logic [BIDX_W-1:0] idx;
        assign idx = done_lo + BIDX_W'(i) - BIDX_W'(seg_off);
        assign line_data[i*8 +: 8] = (enable && seg_be[i]) ? buf_b[idx] : 8'h00;
    end

endmodule

// File: rtl/dma_seg_rpack.sv
`timescale 1ns/1ps
// Merges returned line bytes into the request buffer at the completed position.
module dma_seg_rpack #(
    parameter int LINE_BYTES = 16,
    parameter int BUF_BYTES  = 64,
    parameter int LEN_W      = 7,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [BUF_BYTES*8-1:0]  buf_in,
    input  logic [LINE_BYTES*8-1:0] line_data,
    input  logic [LEN_W-1:0]        done_bytes,
    input  logic [LEN_W-1:0]        issued_bytes,
    input  logic [OFF_W-1:0]        seg_off,
    input  logic                    enable,
    output logic [BUF_BYTES*8-1:0]  buf_out
);
    logic [7:0] line_b [LINE_BYTES];

    for (genvar i = 0; i < LINE_BYTES; i++) begin : g_unpack
        assign line_b[i] = line_data[i*8 +: 8];
    end

    for (genvar j = 0; j < BUF_BYTES; j++) begin : g_byte
        logic [OFF_W-1:0] lane;
        logic             take;
        assign lane = OFF_W'(j) - done_bytes[OFF_W-1:0] + seg_off;
        assign take = enable && ((LEN_W+1)'(j) >= {1'b0, done_bytes})
                             && ((LEN_W+1)'(j) <  {1'b0, issued_bytes});
        assign buf_out[j*8 +: 8] = take ? line_b[lane] : buf_in[j*8 +: 8];
    end

endmodule

// File: rtl/dma_seg_sequencer.sv
`timescale 1ns/1ps
module dma_seg_sequencer
    import dma_seg_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int BUF_BYTES  = 64,
    localparam int LEN_W     = $clog2(BUF_BYTES + 1),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int BIDX_W    = $clog2(BUF_BYTES),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BUF_W     = BUF_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_type,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  req_has_buf,
    input  logic [BUF_W-1:0]      req_wdata,
    output logic [1:0]            req_status,
    output logic                  busy,
    output logic                  seg_valid,
    input  logic                  seg_ready,
    output logic [ADDR_W-1:0]     seg_addr,
    output logic [ADDR_W-1:0]     seg_line_addr,
    output logic [LEN_W-1:0]      seg_len,
    output logic                  seg_write,
    output logic [LINE_BYTES-1:0] seg_be,
    output logic [LINE_W-1:0]     seg_data,
    input  logic                  rsp_valid,
    input  logic                  rsp_is_ack,
    input  logic [LINE_W-1:0]     rsp_data,
    output logic                  done,
    output logic                  proto_err,
    output logic [BUF_W-1:0]      rd_data
);
    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] start;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  done_bytes;
        logic [LEN_W-1:0]  issued;
        logic              write;
        logic              has_buf;
        logic [BUF_W-1:0]  buf_data;
        logic              done_p;
        logic              perr;
    } state_t;

    state_t       state_q, state_d;
    req_status_e  status;
    logic [OFF_W-1:0] cur_off;
    logic [BUF_W-1:0] packed_buf;

    dma_seg_plan #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
    ) u_plan (
        .start_addr (state_q.start),
        .total_len  (state_q.len),
        .done_bytes (state_q.done_bytes),
        .seg_addr   (seg_addr),
        .seg_off    (cur_off),
        .seg_len    (seg_len),
        .seg_be     (seg_be)
    );

    dma_seg_wslice #(
        .LINE_BYTES(LINE_BYTES), .BUF_BYTES(BUF_BYTES)
    ) u_wslice (
        .buf_data  (state_q.buf_data),
        .done_lo   (state_q.done_bytes[BIDX_W-1:0]),
        .seg_off   (cur_off),
        .seg_be    (seg_be),
        .enable    (state_q.write && state_q.has_buf),
        .line_data (seg_data)
    );

    dma_seg_rpack #(
        .LINE_BYTES(LINE_BYTES), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
    ) u_rpack (
        .buf_in       (state_q.buf_data),
        .line_data    (rsp_data),
        .done_bytes   (state_q.done_bytes),
        .issued_bytes (state_q.issued),
        .seg_off      (cur_off),
        .enable       (state_q.has_buf),
        .buf_out      (packed_buf)
    );

    always_comb begin
        state_d        = state_q;
        state_d.done_p = 1'b0;
        state_d.perr   = 1'b0;

        // Request decode: busy check first, then legality.
        status = ST_NONE;
        if (req_valid) begin
            if (state_q.phase != PH_IDLE) begin
                status = ST_FULL;
            end else if (!(req_type == TYPE_LOAD || req_type == TYPE_STORE)
                         || req_len == '0
                         || req_len > LEN_W'(BUF_BYTES)) begin
                status = ST_ERROR;
            end else begin
                status = ST_ISSUED;
            end
        end

        case (state_q.phase)
            PH_IDLE: begin
                if (status == ST_ISSUED) begin
                    state_d.phase      = PH_ISSUE;
                    state_d.start      = req_addr;
                    state_d.len        = req_len;
                    state_d.write      = (req_type == TYPE_STORE);
                    state_d.has_buf    = req_has_buf;
                    state_d.done_bytes = '0;
                    state_d.issued     = '0;
                    state_d.buf_data   = (req_type == TYPE_STORE && req_has_buf)
                                         ? req_wdata : '0;
                end
            end
            PH_ISSUE: begin
                if (seg_ready) begin
                    state_d.issued = state_q.done_bytes + seg_len;
                    state_d.phase  = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_is_ack != state_q.write) begin
                        state_d.perr = 1'b1;
                    end else begin
                        if (!state_q.write) begin
                            state_d.buf_data = packed_buf;
                        end
                        state_d.done_bytes = state_q.issued;
                        if (state_q.issued == state_q.len) begin
                            state_d.phase  = PH_IDLE;
                            state_d.done_p = 1'b1;
                        end else begin
                            state_d.phase  = PH_ISSUE;
                        end
                    end
                end
            end
            default: state_d.phase = PH_IDLE;
        endcase

        if (rsp_valid && state_q.phase != PH_WAIT) begin
            state_d.perr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_status    = status;
    assign busy          = (state_q.phase != PH_IDLE);
    assign seg_valid     = (state_q.phase == PH_ISSUE);
    assign seg_write     = state_q.write;
    assign seg_line_addr = seg_addr & ~ADDR_W'(LINE_BYTES - 1);
    assign done          = state_q.done_p;
    assign proto_err     = state_q.perr;
    assign rd_data       = state_q.buf_data;

endmodule

// File: rtl/dma_seg_sequencer_chk.sv
`timescale 1ns/1ps
module dma_seg_sequencer_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int BUF_BYTES  = 64,
    localparam int LEN_W     = $clog2(BUF_BYTES + 1),
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_type,
    input logic [1:0]        req_status,
    input logic              busy,
    input logic              seg_valid,
    input logic              seg_ready,
    input logic [ADDR_W-1:0] seg_addr,
    input logic [ADDR_W-1:0] seg_line_addr,
    input logic [LEN_W-1:0]  seg_len,
    input logic              rsp_valid,
    input logic              done,
    input logic              proto_err,
    input logic [LEN_W-1:0]  done_bytes
);
    logic [LEN_W:0] seg_end;
    assign seg_end = (LEN_W+1)'(seg_addr[OFF_W-1:0]) + (LEN_W+1)'(seg_len);

    // R1
    refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req_valid |-> req_status == 2'b10);

    // R2
    illegal_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && req_type[1] |=> !busy);

    // R3
    seg_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_len != '0 && seg_end <= (LEN_W+1)'(LINE_BYTES));

    // R4
    later_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && done_bytes != '0 |-> seg_addr[OFF_W-1:0] == '0);

    // R5
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && seg_ready |=> !seg_valid);

    // R6
    done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    idle_rsp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !busy |=> proto_err);

    // R11
    line_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> seg_line_addr[OFF_W-1:0] == '0
                      && seg_line_addr[ADDR_W-1:OFF_W] == seg_addr[ADDR_W-1:OFF_W]);

endmodule

bind dma_seg_sequencer dma_seg_sequencer_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .BUF_BYTES(BUF_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_type      (req_type),
    .req_status    (req_status),
    .busy          (busy),
    .seg_valid     (seg_valid),
    .seg_ready     (seg_ready),
    .seg_addr      (seg_addr),
    .seg_line_addr (seg_line_addr),
    .seg_len       (seg_len),
    .rsp_valid     (rsp_valid),
    .done          (done),
    .proto_err     (proto_err),
    .done_bytes    (state_q.done_bytes)
);

// File: tb/dma_seg_sequencer_test.sv
`timescale 1ns/1ps
module dma_seg_sequencer_test;
    localparam int ADDR_W = 32;
    localparam int LINE   = 16;
    localparam int BUFB   = 64;
    localparam int LEN_W  = 7;
    localparam int LINE_W = LINE * 8;
    localparam int BUF_W  = BUFB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_type = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic req_has_buf = 1'b0;
    logic [BUF_W-1:0] req_wdata = '0;
    logic [1:0] req_status;
    logic busy, seg_valid, seg_write, done, proto_err;
    logic seg_ready = 1'b0;
    logic [ADDR_W-1:0] seg_addr, seg_line_addr;
    logic [LEN_W-1:0] seg_len;
    logic [LINE-1:0] seg_be;
    logic [LINE_W-1:0] seg_data;
    logic rsp_valid = 1'b0;
    logic rsp_is_ack = 1'b0;
    logic [LINE_W-1:0] rsp_data = '0;
    logic [BUF_W-1:0] rd_data;

    always #2.5 clk = ~clk;

    dma_seg_sequencer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .BUF_BYTES(BUFB)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_addr(req_addr), .req_len(req_len), .req_has_buf(req_has_buf),
        .req_wdata(req_wdata), .req_status(req_status), .busy(busy),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_line_addr(seg_line_addr), .seg_len(seg_len), .seg_write(seg_write),
        .seg_be(seg_be), .seg_data(seg_data), .rsp_valid(rsp_valid),
        .rsp_is_ack(rsp_is_ack), .rsp_data(rsp_data), .done(done),
        .proto_err(proto_err), .rd_data(rd_data)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        int                len;
        logic              wr;
        logic              first;
        logic [LINE-1:0]   be;
        logic [LINE_W-1:0] data;
    } seg_t;

    seg_t exp_q[$];
    logic [7:0] mem [256];

    int d_chk = 0, d_fail = 0, m_chk = 0, m_fail = 0;
    int wrong_arm = 0, idle_req = 0, idle_done = 0;

    task automatic dchk(input bit ok, input string rq, input string what,
                        input logic [BUF_W-1:0] act, input logic [BUF_W-1:0] exp);
        d_chk++;
        if (!ok) begin
            d_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string rq, input string what,
                        input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Driver: pushes the expected segments, issues the request, waits for completion.
    task automatic run_xfer(input logic [ADDR_W-1:0] addr, input int len, input bit wr,
                            input bit hb, input bit poke, input string tag);
        logic [BUF_W-1:0] wd, exp_rd;
        int comp, off, n, t;
        seg_t s;
        wd = '0;
        for (int j = 0; j < BUFB; j++) wd[j*8 +: 8] = 8'(j * 5 + len);
        exp_rd = '0;
        if (!wr && hb)
            for (int j = 0; j < len; j++) exp_rd[j*8 +: 8] = mem[8'(addr + ADDR_W'(j))];
        comp = 0;
        while (comp < len) begin
            off = (comp == 0) ? int'(addr % LINE) : 0;
            n = (len - comp < LINE - off) ? len - comp : LINE - off;
            s.addr = addr + ADDR_W'(comp);
            s.len = n;
            s.wr = wr;
            s.first = (comp == 0);
            s.be = '0;
            s.data = '0;
            for (int i = 0; i < n; i++) begin
                s.be[off + i] = 1'b1;
                if (wr && hb) s.data[(off + i)*8 +: 8] = wd[(comp + i)*8 +: 8];
            end
            exp_q.push_back(s);
            comp += n;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_type = wr ? 2'b01 : 2'b00;
        req_addr = addr;
        req_len = LEN_W'(len);
        req_has_buf = hb;
        req_wdata = wd;
        #1;
        dchk(req_status == 2'b01, "R6", {tag, " status on accept"}, BUF_W'(req_status), 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        dchk(busy == 1'b1, "R6", {tag, " busy after accept"}, BUF_W'(busy), 1);
        t = 0;
        while (!done && t < 4000) begin
            @(negedge clk);
            #1;
            t++;
            if (poke && t == 3) begin
                req_valid = 1'b1;
                req_type = 2'b00;
                req_len = 7'd4;
                #1;
                dchk(req_status == 2'b10, "R1", {tag, " refused while busy"},
                     BUF_W'(req_status), 2);
            end
            if (poke && t == 4) req_valid = 1'b0;
        end
        dchk(t < 4000, "R6", {tag, " completion seen"}, BUF_W'(t), 0);
        dchk(busy == 1'b0, "R6", {tag, " free at done"}, BUF_W'(busy), 0);
        dchk(exp_q.size() == 0, "R5", {tag, " all segments issued"}, BUF_W'(exp_q.size()), 0);
        if (!wr)
            dchk(rd_data == exp_rd, hb ? "R7" : "R9", {tag, " packed read buffer"}, rd_data, exp_rd);
        @(negedge clk);
    endtask

    task automatic try_bad(input logic [1:0] typ, input int len, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_type = typ;
        req_addr = 32'h10;
        req_len = LEN_W'(len);
        req_has_buf = 1'b1;
        #1;
        dchk(req_status == 2'b11, "R2", {tag, " error status"}, BUF_W'(req_status), 3);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        dchk(busy == 1'b0 && seg_valid == 1'b0, "R2", {tag, " no start"},
             BUF_W'({busy, seg_valid}), 0);
    endtask

    // Monitor and responder: compares segments against the queue, returns responses.
    initial begin : monitor
        int cyc, rs, wait_c, wrong_sent;
        logic cur_wr;
        logic [ADDR_W-1:0] cur_line;
        seg_t e;
        cyc = 0; rs = 0; wait_c = 0; wrong_sent = 0;
        cur_wr = 1'b0; cur_line = '0;
        for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + 3);
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (rs == 2) begin
                mchk(proto_err == 1'b1, "R10", "wrong-kind response flagged",
                     LINE_W'(proto_err), 1);
                rsp_valid = 1'b1;
                rsp_is_ack = cur_wr;
                for (int i = 0; i < LINE; i++) rsp_data[i*8 +: 8] = mem[8'(cur_line + ADDR_W'(i))];
                rs = 0;
            end else if (rs == 4) begin
                mchk(proto_err == 1'b1 && busy == 1'b0, "R10", "idle response flagged and ignored",
                     LINE_W'({proto_err, busy}), 2);
                idle_done++;
                rs = 0;
            end else if (rs == 1) begin
                if (seg_valid)
                    mchk(1'b0, "R5", "segment offered before response", 1, 0);
                if (wait_c == 0) begin
                    rsp_valid = 1'b1;
                    if (wrong_arm > wrong_sent) begin
                        wrong_sent++;
                        rsp_is_ack = !cur_wr;
                        rsp_data = {LINE{8'hA5}};
                        rs = 2;
                    end else begin
                        rsp_is_ack = cur_wr;
                        for (int i = 0; i < LINE; i++)
                            rsp_data[i*8 +: 8] = mem[8'(cur_line + ADDR_W'(i))];
                        rs = 0;
                    end
                end else begin
                    wait_c--;
                end
            end else if (idle_req > idle_done && !busy) begin
                rsp_valid = 1'b1;
                rsp_is_ack = 1'b1;
                rs = 4;
            end
            cyc++;
            seg_ready = (cyc % 3) != 1;
            if (seg_valid && seg_ready && rs == 0) begin
                if (exp_q.size() == 0) begin
                    mchk(1'b0, "R1", "unexpected segment", LINE_W'(seg_addr), 0);
                end else begin
                    e = exp_q.pop_front();
                    mchk(seg_addr == e.addr, e.first ? "R3" : "R4", "segment address",
                         LINE_W'(seg_addr), LINE_W'(e.addr));
                    mchk(int'(seg_len) == e.len, e.first ? "R3" : "R4", "segment length",
                         LINE_W'(seg_len), LINE_W'(e.len));
                    mchk(seg_line_addr == (e.addr & ~32'(LINE - 1)), "R11", "line address",
                         LINE_W'(seg_line_addr), LINE_W'(e.addr & ~32'(LINE - 1)));
                    mchk(seg_write == e.wr, "R8", "segment direction",
                         LINE_W'(seg_write), LINE_W'(e.wr));
                    mchk(seg_be == e.be, "R8", "byte enables", LINE_W'(seg_be), LINE_W'(e.be));
                    if (e.wr)
                        mchk(seg_data == e.data, (e.data == '0) ? "R9" : "R8", "store slice",
                             seg_data, e.data);
                end
                if (seg_write)
                    for (int i = 0; i < LINE; i++)
                        if (seg_be[i]) mem[8'(seg_line_addr + ADDR_W'(i))] = seg_data[i*8 +: 8];
                cur_wr = seg_write;
                cur_line = seg_line_addr;
                wait_c = 1;
                rs = 1;
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 d_chk + m_chk + 1, d_fail + m_fail + 1);
        $finish;
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        #1;
        dchk(busy == 0 && seg_valid == 0 && done == 0 && proto_err == 0 && rd_data == '0,
             "R6", "reset state", BUF_W'({busy, seg_valid, done, proto_err}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_xfer(32'h05, 7,  1'b0, 1'b1, 1'b0, "read within line");
        run_xfer(32'h0A, 30, 1'b0, 1'b1, 1'b0, "read across lines");
        run_xfer(32'h43, 40, 1'b1, 1'b1, 1'b1, "unaligned write");
        run_xfer(32'h80, 32, 1'b1, 1'b1, 1'b0, "aligned write");
        run_xfer(32'h43, 40, 1'b0, 1'b1, 1'b0, "read back write");
        run_xfer(32'h07, 64, 1'b0, 1'b1, 1'b0, "maximum read");
        run_xfer(32'hC1, 20, 1'b1, 1'b0, 1'b0, "write without buffer");
        run_xfer(32'h30, 5,  1'b0, 1'b0, 1'b0, "read without buffer");

        try_bad(2'b10, 8,  "type 10");
        try_bad(2'b11, 8,  "type 11");
        try_bad(2'b00, 0,  "zero length");
        try_bad(2'b01, 65, "oversize length");

        idle_req++;
        while (idle_done < idle_req) @(negedge clk);
        repeat (2) @(negedge clk);

        wrong_arm++;
        run_xfer(32'h92, 25, 1'b1, 1'b1, 1'b0, "write with stray data");
        wrong_arm++;
        run_xfer(32'h92, 25, 1'b0, 1'b1, 1'b0, "read with stray ack");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 d_chk + m_chk, d_fail + m_fail);
        $finish;
    end

endmodule